// File: doc/BRIEF.md
# Multicore boot release table

This block keeps the secondary processor cores of a multicore cluster parked after reset until software starts them. It contains one 32-byte entry per core, and a plain request/response slave port reads and writes those entries in big-endian byte order with 1-, 2- and 4-byte accesses. Each entry carries a 64-bit start-address word at byte offset 0, a 64-bit argument word at byte offset 8, a 32-bit identity word at byte offset 20, and reserved bytes at offsets 16 to 19 and 24 to 31. The entry for core `i` starts at byte `32*i`.

Software starts a core by writing its start-address word with bit 0 cleared. Every write that the block accepts and that leaves bit 0 of that entry's start address at zero produces a release strobe for that core. The strobe splits the start address over a 64 MiB window: the offset inside the window and the window base. It also carries the argument word. At the same moment, the identity word of the entry is replaced with the core's hardware identifier. The block drops writes to the boot core's entry (index 0) and writes to cores that are absent.

Top module: `boot_release_table`

## Requirements
- R1: After reset, entry `i` holds start address 64'h1, argument `i`, identity word `i`, and zero in every reserved byte. The release strobe and the response are low.
- R2: A read of 1, 2 or 4 bytes (`req_size` = 1, 2 or 4) at any byte offset returns the addressed bytes with the lowest address in the most significant position, right-justified and zero-filled in `rsp_rdata`. Byte addresses wrap at the end of the table. The response appears one clock edge after the request is sampled.
- R3: A read with any other `req_size` value raises `rsp_err` and returns zero data. Writes never raise `rsp_err`.
- R4: A write of 1, 2 or 4 bytes changes only the addressed bytes. The most significant used byte of `req_wdata` goes to the lowest address. Bytes that would fall past the end of the addressed entry are discarded.
- R5: A write with a `req_size` other than 1, 2 or 4 changes no stored byte.
- R6: Writes to entry 0 change nothing and never cause a release.
- R7: Writes to an entry whose bit in `core_present` is 0 change nothing and never cause a release.
- R8: An accepted write that leaves bit 0 of its entry's start address at 0 raises `rel_valid` for exactly one cycle, two clock edges after the request is sampled, with `rel_core` set to the entry index. Every such write produces its own strobe, including back-to-back writes.
- R9: With a release, `rel_start` equals the start address modulo 2^26, `rel_base` equals the start address with bits 25:0 cleared, and `rel_param` equals the argument word. All three are taken from the entry contents after the triggering write.
- R10: In the edge that raises `rel_valid`, the entry's identity word (bytes 20 to 23) takes the value of `core_hwid[32*i +: 32]`. If a bus write in that same edge targets any of those bytes, the bus write's bytes win.
- R11: An accepted write that leaves bit 0 of the start address at 1 causes no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the table |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| req_wdata | input | 32 | Right-justified write value |
| rsp_valid | output | 1 | Response for the request sampled at the previous edge |
| rsp_rdata | output | 32 | Read data, right-justified, zero for writes |
| rsp_err | output | 1 | Read had an illegal size |
| core_present | input | 32 | One bit per core, 1 = core exists |
| core_hwid | input | 1024 | Hardware identifier of core i at bits 32*i+31:32*i |
| rel_valid | output | 1 | One-cycle release strobe |
| rel_core | output | 5 | Index of the released core |
| rel_start | output | 64 | Start offset inside the 64 MiB window |
| rel_base | output | 64 | Base of the 64 MiB window |
| rel_param | output | 64 | Argument word for the released core |

## Verification
The block produces results on three timescales. The response to a request is due one edge after the request is sampled. The release strobe and its payload are due one edge later. The identity write-back is due in the same edge as the strobe, so a read sampled at the following edge shows it. The bench's reference model advances at every rising edge in this order: the read is answered from the state before the edge, then the pending release and write-back from the previous edge's write are applied, then the current write is applied. Outputs are compared with the model at every falling edge, so each result is checked in the cycle where it is due and never early or late.

// File: rtl/brt_pkg.sv
// Shared constants, types and helpers for the boot release table.
// Assumes every entry is exactly 32 bytes with big-endian fields.
package brt_pkg;

    localparam int ENTRY_BYTES = 32;
    localparam int OFF_W       = 5;
    localparam int START_OFS   = 0;
    localparam int ARG_OFS     = 8;
    localparam int IDENT_OFS   = 20;
    localparam int IDENT_BYTES = 4;

    // One entry viewed as a vector of bytes, index = byte offset.
    typedef logic [ENTRY_BYTES-1:0][7:0] entry_img_t;

    // Number of bytes moved by a size code; zero marks an illegal size.
    function automatic int size_bytes(input logic [2:0] code);
        case (code)
            3'd1:    return 1;
            3'd2:    return 2;
            3'd4:    return 4;
            default: return 0;
        endcase
    endfunction

    // Gather a big-endian 64-bit field starting at byte offset ofs.
    function automatic logic [63:0] get_u64(input entry_img_t e, input int ofs);
        logic [63:0] r;
        r = '0;
        for (int b = 0; b < 8; b++) begin
            r = {r[55:0], e[ofs+b]};
        end
        return r;
    endfunction

endpackage

// File: rtl/brt_access.sv
// Access decoder: turns one bus request into per-byte write enables and
// write bytes for a single entry, and decides whether the write is kept.
// Assumes the request is stable for the cycle; purely combinational.
module brt_access
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int IDX_W     = 5,
    parameter int ADDR_W    = 10
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_size,
    input  logic [31:0]          req_wdata,
    input  logic [NUM_CORES-1:0] core_present,
    output logic                 wr_accept,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [ENTRY_BYTES-1:0] wr_be,
    output entry_img_t           wr_bytes,
    output logic                 size_ok
);

    int nbytes;
    int first;

    // Lane steering: byte k of the entry receives value byte (n-1-(k-first)).
    always_comb begin
        nbytes   = size_bytes(req_size);
        first    = int'(req_addr[OFF_W-1:0]);
        wr_be    = '0;
        wr_bytes = '0;
        for (int k = 0; k < ENTRY_BYTES; k++) begin
            if ((k >= first) && ((k - first) < nbytes)) begin
                wr_be[k]    = 1'b1;
                wr_bytes[k] = 8'(req_wdata >> (8 * (nbytes - 1 - (k - first))));
            end
        end
    end

    // Write filter: legal size, not the boot core, core present.
    always_comb begin
        wr_idx    = req_addr[ADDR_W-1:OFF_W];
        size_ok   = (nbytes != 0);
        wr_accept = req_valid && req_write && size_ok &&
                    (wr_idx != '0) && (int'(wr_idx) < NUM_CORES) &&
                    core_present[wr_idx];
    end

endmodule

// File: rtl/brt_entry.sv
// Storage for one core's 32-byte entry with its reset image.
// Assumes at most one bus write and one identity write-back per edge;
// bus bytes take priority over the write-back on overlapping bytes.
module brt_entry
    import brt_pkg::*;
#(
    parameter int ENTRY_IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ENTRY_BYTES-1:0] wr_be,
    input  entry_img_t             wr_bytes,
    input  logic                   wb_en,
    input  logic [31:0]            wb_id,
    output entry_img_t             img
);

    // Reset image: start address 1 (held), argument and identity = index.
    function automatic entry_img_t reset_img();
        entry_img_t r;
        r = '0;
        r[START_OFS+7] = 8'h01;
        for (int b = 0; b < 8; b++) begin
            r[ARG_OFS+b] = 8'(64'(ENTRY_IDX) >> (8 * (7 - b)));
        end
        for (int b = 0; b < IDENT_BYTES; b++) begin
            r[IDENT_OFS+b] = 8'(32'(ENTRY_IDX) >> (8 * (IDENT_BYTES - 1 - b)));
        end
        return r;
    endfunction

    // Byte registers: reset, bus write, else identity write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img <= reset_img();
        end else begin
            for (int k = 0; k < ENTRY_BYTES; k++) begin
                if (wr_en && wr_be[k]) begin
                    img[k] <= wr_bytes[k];
                end else if (wb_en && (k >= IDENT_OFS) && (k < IDENT_OFS + IDENT_BYTES)) begin
                    img[k] <= 8'(wb_id >> (8 * (IDENT_OFS + IDENT_BYTES - 1 - k)));
                end
            end
        end
    end

endmodule

// File: rtl/brt_release.sv
// Release sequencer: remembers the entry written at the last edge, tests
// its start-address bit 0, and drives the release strobe and write-back.
// Assumes the caller presents the pending entry's fields combinationally.
module brt_release
    import brt_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int WIN_BITS = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] pend_idx,
    input  logic [63:0]      sel_start,
    input  logic [63:0]      sel_arg,
    input  logic [31:0]      sel_hwid,
    output logic             wb_en,
    output logic [31:0]      wb_id,
    output logic             rel_valid,
    output logic [IDX_W-1:0] rel_core,
    output logic [63:0]      rel_start,
    output logic [63:0]      rel_base,
    output logic [63:0]      rel_param
);

    localparam logic [63:0] WIN_MASK = (64'd1 << WIN_BITS) - 64'd1;

    logic pend_v;

    // Pending stage: capture each accepted write for evaluation next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
        end else begin
            pend_v   <= wr_accept;
            pend_idx <= wr_idx;
        end
    end

    // Release decision on the updated entry; also drives the write-back.
    always_comb begin
        wb_en = pend_v && !sel_start[0];
        wb_id = sel_hwid;
    end

    // Release outputs: one-cycle strobe, payload held until the next fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_core  <= '0;
            rel_start <= '0;
            rel_base  <= '0;
            rel_param <= '0;
        end else begin
            rel_valid <= wb_en;
            if (wb_en) begin
                rel_core  <= pend_idx;
                rel_start <= sel_start & WIN_MASK;
                rel_base  <= sel_start & ~WIN_MASK;
                rel_param <= sel_arg;
            end
        end
    end

endmodule

// File: rtl/boot_release_table.sv
// Top of the multicore boot release table: slave port, per-core entries,
// big-endian read path and release sequencer.
// Assumes one request per cycle and a response one edge later.
module boot_release_table
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int WIN_BITS  = 26,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int ADDR_W   = IDX_W + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2:0]              req_size,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    output logic                    rsp_err,
    input  logic [NUM_CORES-1:0]    core_present,
    input  logic [NUM_CORES*32-1:0] core_hwid,
    output logic                    rel_valid,
    output logic [IDX_W-1:0]        rel_core,
    output logic [63:0]             rel_start,
    output logic [63:0]             rel_base,
    output logic [63:0]             rel_param
);

    localparam int TBL_BYTES = NUM_CORES * ENTRY_BYTES;

    logic                   wr_accept;
    logic [IDX_W-1:0]       wr_idx;
    logic [ENTRY_BYTES-1:0] wr_be;
    entry_img_t             wr_bytes;
    logic                   size_ok;
    logic [IDX_W-1:0]       pend_idx;
    logic                   wb_en;
    logic [31:0]            wb_id;
    entry_img_t             img [NUM_CORES];
    logic [TBL_BYTES-1:0][7:0] tbl;
    entry_img_t             sel_img;
    logic [63:0]            sel_start;
    logic [63:0]            sel_arg;
    logic [31:0]            sel_hwid;
    logic [31:0]            rd_data;
    int                     rd_n;

    brt_access #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_access (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_wdata    (req_wdata),
        .core_present (core_present),
        .wr_accept    (wr_accept),
        .wr_idx       (wr_idx),
        .wr_be        (wr_be),
        .wr_bytes     (wr_bytes),
        .size_ok      (size_ok)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_entry
        brt_entry #(
            .ENTRY_IDX (i)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_accept && (wr_idx == IDX_W'(i))),
            .wr_be    (wr_be),
            .wr_bytes (wr_bytes),
            .wb_en    (wb_en && (pend_idx == IDX_W'(i))),
            .wb_id    (wb_id),
            .img      (img[i])
        );
        assign tbl[i*ENTRY_BYTES +: ENTRY_BYTES] = img[i];
    end

    // Field selection for the entry written at the previous edge.
    always_comb begin
        sel_img   = img[pend_idx];
        sel_start = get_u64(sel_img, START_OFS);
        sel_arg   = get_u64(sel_img, ARG_OFS);
        sel_hwid  = core_hwid[int'(pend_idx)*32 +: 32];
    end

    brt_release #(
        .IDX_W    (IDX_W),
        .WIN_BITS (WIN_BITS)
    ) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wr_idx    (wr_idx),
        .pend_idx  (pend_idx),
        .sel_start (sel_start),
        .sel_arg   (sel_arg),
        .sel_hwid  (sel_hwid),
        .wb_en     (wb_en),
        .wb_id     (wb_id),
        .rel_valid (rel_valid),
        .rel_core  (rel_core),
        .rel_start (rel_start),
        .rel_base  (rel_base),
        .rel_param (rel_param)
    );

    // Read path: gather up to four bytes from the flat table, MSB first.
    always_comb begin
        rd_n    = size_bytes(req_size);
        rd_data = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < rd_n) begin
                rd_data = {rd_data[23:0], tbl[(int'(req_addr) + j) % TBL_BYTES]};
            end
        end
    end

    // Response register: one response per request, error on bad read size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !req_write && !size_ok;
            rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
        end
    end

endmodule

// File: rtl/brt_checker.sv
// Property checker for the boot release table, bound to the top module.
// Assumes synchronous active-low reset; all properties disabled in reset.
module brt_checker #(
    parameter int NUM_CORES = 32,
    parameter int IDX_W     = 5,
    parameter int WIN_BITS  = 26
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [IDX_W-1:0]       req_idx,
    input logic [2:0]             req_size,
    input logic [NUM_CORES-1:0]   core_present,
    input logic                   rsp_valid,
    input logic                   rsp_err,
    input logic                   rel_valid,
    input logic [IDX_W-1:0]       rel_core,
    input logic [63:WIN_BITS]     start_hi,
    input logic [WIN_BITS-1:0]    base_lo
);

    logic legal;
    logic acc_ok;

    // Independent view of a kept write, from the port signals only.
    always_comb begin
        legal  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
        acc_ok = req_valid && req_write && legal && (req_idx != '0) &&
                 core_present[req_idx];
    end

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_idle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_err_on_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !legal) |=> rsp_err);

    a_r3_no_err_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_write || legal)) |=> !rsp_err);

    a_r6_boot_core_never_released: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_core != '0));

    a_r7_release_needs_kept_write: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(acc_ok, 2));

    a_r8_release_core_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_core == $past(req_idx, 2)));

    a_r9_window_split: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ((start_hi == '0) && (base_lo == '0)));

endmodule

bind boot_release_table brt_checker #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W),
    .WIN_BITS  (WIN_BITS)
) u_brt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_idx      (req_addr[ADDR_W-1:5]),
    .req_size     (req_size),
    .core_present (core_present),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rel_valid    (rel_valid),
    .rel_core     (rel_core),
    .start_hi     (rel_start[63:WIN_BITS]),
    .base_lo      (rel_base[WIN_BITS-1:0])
);

// File: tb/boot_release_table_tb_top.sv
`timescale 1ns/1ps
// Bench for the boot release table: behavioural byte-array model stepped
// at each rising edge, outputs compared at each falling edge.
module boot_release_table_tb_top;

    localparam int NC    = 32;
    localparam int TBL   = NC * 32;
    localparam int WIN   = 26;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [9:0]   req_addr = '0;
    logic [2:0]   req_size = 3'd0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         rsp_err;
    logic [NC-1:0]    core_present = 32'h7FFF_FFDF;
    logic [NC*32-1:0] core_hwid;
    logic         rel_valid;
    logic [4:0]   rel_core;
    logic [63:0]  rel_start;
    logic [63:0]  rel_base;
    logic [63:0]  rel_param;

    always #5 clk = ~clk;

    boot_release_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .core_present(core_present), .core_hwid(core_hwid),
        .rel_valid(rel_valid), .rel_core(rel_core), .rel_start(rel_start),
        .rel_base(rel_base), .rel_param(rel_param)
    );

    // ---------------- reference model ----------------
    logic [7:0]  mem [TBL];
    bit          pend_v;
    int          pend_e;
    bit          e_rsp_v, e_err, e_rel_v;
    logic [31:0] e_rdata;
    int          e_core;
    logic [63:0] e_start, e_base, e_param;
    bit          started = 0;
    string       cur_tag = "R1";
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    function automatic logic [63:0] rd64(input int a);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) r = {r[55:0], mem[a+b]};
        return r;
    endfunction

    function automatic int nsz(input logic [2:0] s);
        return (s == 3'd1) ? 1 : (s == 3'd2) ? 2 : (s == 3'd4) ? 4 : 0;
    endfunction

    always @(posedge clk) begin
        int n, a, e, o;
        logic [63:0] sa;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < TBL; i++) mem[i] = 8'h00;
            for (int i = 0; i < NC; i++) begin
                mem[i*32+7]  = 8'h01;
                mem[i*32+15] = 8'(i);
                mem[i*32+23] = 8'(i);
            end
            pend_v = 0; e_rsp_v = 0; e_err = 0; e_rdata = '0; e_rel_v = 0;
        end else begin
            n = nsz(req_size);
            a = int'(req_addr);
            // response from the state before this edge
            e_rsp_v = req_valid; e_err = 0; e_rdata = '0;
            if (req_valid && !req_write) begin
                if (n == 0) e_err = 1;
                for (int j = 0; j < n; j++) e_rdata = {e_rdata[23:0], mem[(a+j) % TBL]};
            end
            // release for the write kept at the previous edge
            e_rel_v = 0;
            if (pend_v) begin
                sa = rd64(pend_e*32);
                if (!sa[0]) begin
                    e_rel_v = 1;
                    e_core  = pend_e;
                    e_start = sa % (64'd1 << WIN);
                    e_base  = sa - e_start;
                    e_param = rd64(pend_e*32 + 8);
                    for (int b = 0; b < 4; b++)
                        mem[pend_e*32+20+b] = 8'(core_hwid[pend_e*32 +: 32] >> (8*(3-b)));
                end
            end
            // current write, later in time than the write-back
            pend_v = 0;
            if (req_valid && req_write && n != 0) begin
                e = a / 32;
                if (e != 0 && core_present[e]) begin
                    for (int j = 0; j < n; j++) begin
                        o = (a % 32) + j;
                        if (o < 32) mem[e*32+o] = 8'(req_wdata >> (8*(n-1-j)));
                    end
                    pend_v = 1;
                    pend_e = e;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_tag, "rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
            if (e_rsp_v) begin
                chk(cur_tag, "rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
                chk("R3", "rsp_err", 64'(rsp_err), 64'(e_err));
            end
            chk("R8", "rel_valid", 64'(rel_valid), 64'(e_rel_v));
            if (e_rel_v) begin
                chk("R8", "rel_core", 64'(rel_core), 64'(e_core));
                chk("R9", "rel_start", rel_start, e_start);
                chk("R9", "rel_base", rel_base, e_base);
                chk("R9", "rel_param", rel_param, e_param);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input bit wr, input int addr, input int sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 10'(addr);
        req_size = 3'(sz); req_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) core_hwid[i*32 +: 32] = 32'hA500_0000 | 32'(i * 17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";
        acc(0, 3*32+0, 4, 0); acc(0, 3*32+4, 4, 0); acc(0, 3*32+12, 4, 0);
        acc(0, 3*32+20, 4, 0); acc(0, 3*32+16, 4, 0); acc(0, 0*32+4, 4, 0);
        idle(2);

        cur_tag = "R2";
        acc(0, 7*32+15, 1, 0); acc(0, 7*32+22, 2, 0); acc(0, 7*32+5, 4, 0);
        acc(0, TBL-2, 4, 0); acc(0, TBL-1, 2, 0);
        idle(2);

        cur_tag = "R3";
        acc(0, 40, 3, 0); acc(0, 41, 0, 0); acc(0, 42, 7, 0); acc(1, 2*32+9, 3, 32'hFFFF_FFFF);
        idle(2);

        cur_tag = "R4";
        acc(1, 2*32+9, 2, 32'h1234_BEEF); acc(0, 2*32+8, 4, 0);
        acc(1, 2*32+30, 4, 32'hCAFE_F00D); acc(0, 2*32+28, 4, 0); acc(0, 3*32+0, 4, 0);
        acc(1, 2*32+17, 1, 32'h0000_005A); acc(0, 2*32+16, 4, 0);
        idle(2);

        cur_tag = "R5";
        acc(1, 2*32+4, 5, 32'h0000_0000); acc(1, 2*32+4, 0, 32'h0); acc(0, 2*32+4, 4, 0);
        idle(3);

        cur_tag = "R6";
        acc(1, 0*32+4, 4, 32'h0000_1000); acc(0, 0*32+4, 4, 0);
        idle(3);

        cur_tag = "R7";
        acc(1, 5*32+4, 4, 32'h0000_2000); acc(0, 5*32+4, 4, 0);
        acc(1, 31*32+4, 4, 32'h0000_3000); acc(0, 31*32+4, 4, 0);
        idle(3);

        cur_tag = "R11";
        acc(1, 4*32+8, 4, 32'h1111_2222); acc(1, 4*32+4, 4, 32'h0800_0003);
        acc(0, 4*32+20, 4, 0);
        idle(3);

        cur_tag = "R9";
        acc(1, 3*32+12, 4, 32'hDEAD_0003); acc(1, 3*32+0, 4, 32'h0000_0001);
        acc(1, 3*32+4, 4, 32'h0ABC_DEF0);
        idle(3);

        cur_tag = "R10";
        acc(0, 3*32+20, 4, 0); acc(0, 3*32+22, 2, 0);
        idle(2);

        cur_tag = "R8";
        acc(1, 3*32+7, 1, 32'h0000_0040); acc(1, 4*32+7, 1, 32'h0000_0010);
        acc(1, 6*32+3, 1, 32'h0000_0011); acc(1, 3*32+6, 2, 32'h0000_7700);
        idle(3);

        cur_tag = "R10";
        acc(1, 9*32+4, 4, 32'h0000_4000); acc(1, 9*32+21, 2, 32'h0000_ABCD);
        acc(0, 9*32+20, 4, 0);
        idle(3);

        cur_tag = "R4";
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 3));
            acc(bit'($urandom_range(0, 1)), int'($urandom_range(0, TBL-1)),
                (sel == 3) ? 3 : (1 << sel), $urandom());
        end
        idle(4);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule